// File: doc/BRIEF.md
# Decade Counter with Wrap Flag

This block is a synchronous modulo-10 counter. Its 4-bit BCD state steps through the decimal digits 0 to 9 and then returns to 0. Each state bit is a toggle element with its own toggle-enable term. There is no adder. The four toggle enables come out on a port, so a neighbour or a checker can see which bits move on the next edge.

An active-low flag marks the single wrapping step. It reads 0 only while the present state is nine, which is the state whose next edge returns the counter to zero. It is purely combinational on the present state. It therefore follows the state whether or not counting is enabled.

Codes 10 to 15 are not decimal digits. If such a code ever appears in the state, the next enabled edge clears it to zero, and the flag stays high while the code is present. A synchronous active-low reset clears the state and overrides the count enable.

Top module: `decade_tick_counter`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the state becomes 0000 whatever `cnt_en` is, and `tog_en` reads 0000 for as long as `rst_n` is low.
- R2: With `rst_n` high and `cnt_en` high, each rising edge moves a legal state s to s+1 for s below 9, and moves 9 to 0, so the sequence 0,1,...,9,0 repeats.
- R3: With `cnt_en` low, `tog_en` reads 0000 and the state holds across the edge.
- R4: In a legal state with counting active, `tog_en[0]` (the weight-1 bit) is 1.
- R5: In a legal state with counting active, `tog_en[1]` (weight-2 bit) is 1 exactly when state bit 0 is 1 and state bit 3 is 0.
- R6: In a legal state with counting active, `tog_en[2]` (weight-4 bit) is 1 exactly when state bits 1 and 0 are both 1.
- R7: In a legal state with counting active, `tog_en[3]` (weight-8 bit) is 1 only in states 0111 and 1001.
- R8: `wrap_n` is 0 exactly when the state is 1001, independent of `cnt_en`. An enabled edge taken while `wrap_n` is 0 yields state 0000.
- R9: In a state from 1010 to 1111, `wrap_n` reads 1. With counting active, `tog_en` equals the state, so that the next edge yields 0000. With `cnt_en` low, the illegal code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable, active high |
| state_q | output | 4 | Present BCD state; bit 3 has weight 8, bit 0 has weight 1 |
| wrap_n | output | 1 | Low while the state is nine (the wrapping step) |
| tog_en | output | 4 | Per-bit toggle enables applied at the next edge; bit i toggles state bit i |

## Verification
Two pairs of functions can meet in one cycle. The first is reset against count enable. The bench drives `rst_n` low with `cnt_en` high while the counter sits at nine. The check expects the state to go to zero, `tog_en` to read zero, and the flag to stay low during that cycle, because it still reflects state nine. The second is illegal-code recovery against a held count. An illegal code is injected into the state register while `cnt_en` is low. The scoreboard expects the code to persist with `wrap_n` high, and then to clear on the first enabled edge.

// File: rtl/dcnt_pkg.sv
// Package dcnt_pkg
// Shared constants and the digit type for the decade counter.
// Assumes a 4-bit BCD code, where bit 3 has weight 8 and bit 0 has weight 1.
package dcnt_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t FIRST_CODE = digit_t'(0);
    localparam digit_t LAST_CODE  = digit_t'(9);

    // Bit positions by weight
    localparam int W1 = 0;
    localparam int W2 = 1;
    localparam int W4 = 2;
    localparam int W8 = 3;

    // True when the code is a decimal digit
    function automatic logic is_digit(input digit_t c);
        return c <= LAST_CODE;
    endfunction
endpackage

// File: rtl/dcnt_toggle_gen.sv
// Module dcnt_toggle_gen
// Derives the four toggle enables from the present state.
// Assumes `advance` already combines count enable with reset deassertion.
// In an illegal code, every set bit is toggled, so the next state is zero.
module dcnt_toggle_gen
    import dcnt_pkg::*;
(
    input  digit_t state,
    input  logic   advance,
    output digit_t tog
);
    // Toggle-enable terms for legal digits, or the clear pattern for illegal codes
    always_comb begin
        tog = '0;
        if (advance) begin
            if (!is_digit(state)) begin
                tog = state;
            end else begin
                tog[W1] = 1'b1;
                tog[W2] = state[W1] & ~state[W8];
                tog[W4] = state[W2] & state[W1];
                tog[W8] = (state[W4] & state[W2] & state[W1])
                        | (state[W8] & state[W1]);
            end
        end
    end
endmodule

// File: rtl/dcnt_store.sv
// Module dcnt_store
// A bank of toggle storage bits. Bit i flips when tog[i] is 1 and holds otherwise.
// Assumes a synchronous active-low reset that clears every bit.
module dcnt_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] tog,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;

    // Clear on reset, otherwise flip the selected bits
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_r ^ tog;
    end

    assign q = q_r;
endmodule

// File: rtl/dcnt_flag.sv
// Module dcnt_flag
// Active-low wrap flag, which is low only in the last decimal digit.
// Assumes an illegal code is not the last digit, so the flag stays high there.
module dcnt_flag
    import dcnt_pkg::*;
(
    input  digit_t state,
    output logic   wrap_n
);
    // Compare the present state with the last digit
    always_comb wrap_n = (state != LAST_CODE);
endmodule

// File: rtl/decade_tick_counter.sv
// Module decade_tick_counter
// Synchronous modulo-10 counter built from toggle bits. It exposes the toggle
// enables and an active-low flag for the nine-to-zero step.
// Assumes one clock domain and a synchronous active-low reset that overrides cnt_en.
module decade_tick_counter
    import dcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    output logic [DIGIT_W-1:0] state_q,
    output logic               wrap_n,
    output logic [DIGIT_W-1:0] tog_en
);
    digit_t state_w;
    digit_t tog_w;
    logic   advance;

    // Counting happens only when enabled and out of reset
    assign advance = cnt_en & rst_n;

    dcnt_toggle_gen u_tgen (
        .state   (state_w),
        .advance (advance),
        .tog     (tog_w)
    );

    dcnt_store #(.WIDTH(DIGIT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .tog   (tog_w),
        .q     (state_w)
    );

    dcnt_flag u_flag (
        .state  (state_w),
        .wrap_n (wrap_n)
    );

    assign state_q = state_w;
    assign tog_en  = tog_w;
endmodule

// File: rtl/dcnt_checks.sv
// Module dcnt_checks
// Temporal checks on the ports of decade_tick_counter, attached by bind.
module dcnt_checks
    import dcnt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_en,
    input logic [DIGIT_W-1:0] state_q,
    input logic               wrap_n,
    input logic [DIGIT_W-1:0] tog_en
);
    logic primed;

    // Marks that at least one edge has passed, so $past is meaningful
    always_ff @(posedge clk) primed <= 1'b1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        (primed === 1'b1) && !rst_n && !$past(rst_n) |-> (state_q == FIRST_CODE) && (tog_en == '0));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q < LAST_CODE) |=> state_q == digit_t'($past(state_q) + digit_t'(1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(state_q));

    assert_idle_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> tog_en == '0);

    assert_lsb_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q <= LAST_CODE) |=> state_q[W1] != $past(state_q[W1]));

    assert_w2_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q <= LAST_CODE) |=>
        state_q[W2] == ($past(state_q[W2]) ^ ($past(state_q[W1]) & ~$past(state_q[W8]))));

    assert_w4_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q <= LAST_CODE) |=>
        state_q[W4] == ($past(state_q[W4]) ^ ($past(state_q[W2]) & $past(state_q[W1]))));

    assert_w8_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q <= LAST_CODE) && !(state_q == 4'd7 || state_q == 4'd9) |=>
        $stable(state_q[W8]));

    assert_flag_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_n && cnt_en |=> state_q == FIRST_CODE);

    assert_flag_low_at_nine_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LAST_CODE) |-> !wrap_n);

    assert_illegal_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && (state_q > LAST_CODE) |=> state_q == FIRST_CODE);

    assert_illegal_flag_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q > LAST_CODE) |-> wrap_n);
endmodule

bind decade_tick_counter dcnt_checks u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .state_q (state_q),
    .wrap_n  (wrap_n),
    .tog_en  (tog_en)
);

// File: tb/decade_tick_counter_test.sv
`timescale 1ns/1ps
module decade_tick_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] state_q;
    logic       wrap_n;
    logic [3:0] tog_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] st;
        logic       y;
        logic [3:0] tg;
        logic       rstn;
        logic       en;
    } exp_t;

    exp_t       sb_q[$];
    logic [3:0] model_s = 4'd0;

    always #2.5 clk = ~clk;

    decade_tick_counter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .state_q (state_q),
        .wrap_n  (wrap_n),
        .tog_en  (tog_en)
    );

    // Next digit, as the requirements give it
    function automatic logic [3:0] next_of(input logic [3:0] s);
        return (s >= 4'd9) ? 4'd0 : s + 4'd1;
    endfunction

    // Pushes the expected outputs for this cycle, then advances the model
    task automatic push_expect(input logic rn, input logic en);
        exp_t e;
        e.st   = model_s;
        e.y    = (model_s != 4'd9);
        e.tg   = (rn && en) ? (model_s ^ next_of(model_s)) : 4'd0;
        e.rstn = rn;
        e.en   = en;
        sb_q.push_back(e);
        if (!rn)     model_s = 4'd0;
        else if (en) model_s = next_of(model_s);
    endtask

    // Driver: applies inputs for one cycle
    task automatic drive(input logic rn, input logic en);
        @(negedge clk);
        rst_n  = rn;
        cnt_en = en;
        push_expect(rn, en);
    endtask

    // Driver: places an illegal code in the state for one cycle
    task automatic inject(input logic [3:0] code, input logic en);
        @(negedge clk);
        rst_n  = 1'b1;
        cnt_en = en;
        force uut.u_store.q_r = code;
        release uut.u_store.q_r;
        model_s = code;
        push_expect(1'b1, en);
    endtask

    // Monitor: pops the expected items and compares them with the ports
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            string tg_st;
            e = sb_q.pop_front();
            if (!e.rstn)      tg_st = "R1";
            else if (e.st > 9) tg_st = "R9";
            else if (!e.en)   tg_st = "R3";
            else              tg_st = "R2";
            checks++;
            if (state_q !== e.st) begin
                errors++;
                $display("FAIL %s state: actual %0d expected %0d", tg_st, state_q, e.st);
            end
            checks++;
            if (wrap_n !== e.y) begin
                errors++;
                $display("FAIL %s wrap_n: actual %0b expected %0b", (e.st > 9) ? "R9" : "R8", wrap_n, e.y);
            end
            for (int b = 0; b < 4; b++) begin
                string tg_t;
                if (!e.rstn)       tg_t = "R1";
                else if (e.st > 9) tg_t = "R9";
                else if (!e.en)    tg_t = "R3";
                else if (b == 0)   tg_t = "R4";
                else if (b == 1)   tg_t = "R5";
                else if (b == 2)   tg_t = "R6";
                else               tg_t = "R7";
                checks++;
                if (tog_en[b] !== e.tg[b]) begin
                    errors++;
                    $display("FAIL %s tog_en[%0d]: actual %0b expected %0b", tg_t, b, tog_en[b], e.tg[b]);
                end
            end
        end
    end

    // Stimulus
    initial begin
        drive(1'b0, 1'b1);                    // R1 reset wins over enable
        drive(1'b0, 1'b0);
        for (int i = 0; i < 25; i++) drive(1'b1, 1'b1);  // R2, R4..R8 over 2.5 decades
        for (int i = 0; i < 3; i++)  drive(1'b1, 1'b0);  // R3 hold at 5
        for (int i = 0; i < 4; i++)  drive(1'b1, 1'b1);  // reach 9
        drive(1'b1, 1'b0);                    // R8 flag low while held at nine
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b1);                    // R1 reset collides with enable at nine
        drive(1'b1, 1'b1);
        for (int c = 10; c < 16; c++) begin   // R9 each illegal code
            drive(1'b0, 1'b0);
            inject(4'(c), 1'b1);
            drive(1'b1, 1'b1);
        end
        drive(1'b0, 1'b0);                    // R9 illegal code held by disabled count
        inject(4'd12, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule